// File: doc/BRIEF.md
# Horizontal Saturating Word Adder

This block is a single-stage SIMD datapath. Each 128-bit lane holds eight signed 16-bit words. The block adds every adjacent pair of those words and clamps each sum to the signed 16-bit range. Within a lane, the four sums taken from the first operand fill the lower half of the result, and the four sums taken from the second operand fill the upper half.

A two-bit mode input controls the top 128 bits of the result:
- The 256-bit mode computes the upper lane from the upper halves of the two operands.
- The 128-bit mode forces the top 128 bits to zero.
- The legacy mode carries the top 128 bits over from the prior destination. In this mode the prior destination's lower half also replaces the first operand.

The block takes operands on a valid/ready input and returns results on a valid/ready output. A transfer happens on a rising clock edge when valid and ready are both high. The output register is the only storage. Input ready is high when the register is empty or when the consumer takes the current result in the same cycle. If the consumer stalls, the result and its valid are held and no new operands are accepted.

Top module: `hsat_word_adder`

## Requirements
- R1: Each result word equals the signed sum of one adjacent pair of words (word 2k+1 plus word 2k, words counted from bit 0 in 16-bit steps) of a source lane, after saturation.
- R2: In each 128-bit lane, result words 0..3 come from the pairs of the first operand in pair order, and result words 4..7 come from the pairs of the second operand in pair order.
- R3: With mode 2'b10, result bits 255:128 follow R2 using src_a[255:128] and src_b[255:128] only. The lower result lane uses only bits 127:0 of both operands.
- R4: With mode 2'b01 or 2'b11, result bits 255:128 are zero and the lower lane follows R2 with src_a and src_b.
- R5: With mode 2'b00, dst_old[127:0] replaces src_a as the first operand of the lower lane, src_a has no effect, and result bits 255:128 equal dst_old[255:128].
- R6: Sums above 32767 give 0x7FFF and sums below -32768 give 0x8000: 0x7FFF+0x0001 gives 0x7FFF, 0x8000+0xFFFF gives 0x8000, 0x8000+0x8000 gives 0x8000.
- R7: A transfer accepted at a clock edge sets out_valid and puts its result on the output at that same edge.
- R8: A synchronous active-high rst clears out_valid and result to zero.
- R9: While out_valid is high and out_ready is low, result and out_valid keep their values and in_ready is low.
- R10: in_ready is high whenever out_valid is low or out_ready is high. With in_valid low and out_ready high, out_valid falls at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operands and mode are valid |
| in_ready | output | 1 | Block can accept operands this cycle |
| mode | input | 2 | 00 legacy, 01/11 128-bit zeroing, 10 256-bit |
| src_a | input | 256 | First operand |
| src_b | input | 256 | Second operand |
| dst_old | input | 256 | Prior destination value, used in legacy mode |
| out_valid | output | 1 | Result register holds an unread result |
| out_ready | input | 1 | Consumer takes the result this cycle |
| result | output | 256 | Registered packed result |

## Verification
The bench drives the three clamp cases: 0x7FFF+0x0001, 0x8000+0xFFFF and 0x8000+0x8000. A wrapping adder returns 0x8000, 0x7FFF and 0x0000 for these. A sign test on the wrong sum bit misses one of the two overflow directions. Distinct word values in each position catch swapped operand halves or a pair order reversed inside a lane. The upper-lane checks catch lanes mixed across operands in 256-bit mode, a stale upper half left in 128-bit mode, and in legacy mode either src_a leaking into the result or the upper half being zeroed. A stall test confirms that a result held under back-pressure is neither overwritten nor dropped.

// File: rtl/hsat_pkg.sv
package hsat_pkg;
  typedef enum logic [1:0] {
    MODE_LEGACY = 2'b00,
    MODE_V128   = 2'b01,
    MODE_V256   = 2'b10,
    MODE_V128B  = 2'b11
  } hmode_e;
endpackage

// File: rtl/sat_pair_add.sv
module sat_pair_add #(
  parameter int W = 16
) (
  input  logic [W-1:0] hi,
  input  logic [W-1:0] lo,
  output logic [W-1:0] sum
);
  localparam logic [W-1:0] POS_MAX = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0] NEG_MIN = {1'b1, {(W-1){1'b0}}};

  logic [W:0] wide;

  always_comb begin
    wide = {hi[W-1], hi} + {lo[W-1], lo};
    case (wide[W:W-1])
      2'b01:   sum = POS_MAX;
      2'b10:   sum = NEG_MIN;
      default: sum = wide[W-1:0];
    endcase
  end
endmodule

// File: rtl/hadd_lane.sv
module hadd_lane #(
  parameter int W      = 16,
  parameter int LANE_W = 128
) (
  input  logic [LANE_W-1:0] opa,
  input  logic [LANE_W-1:0] opb,
  output logic [LANE_W-1:0] y
);
  localparam int PAIRS = LANE_W / (2 * W);

  for (genvar p = 0; p < PAIRS; p++) begin : g_pair
    sat_pair_add #(.W(W)) u_sa (
      .hi  (opa[(2*p+1)*W +: W]),
      .lo  (opa[(2*p)*W +: W]),
      .sum (y[p*W +: W])
    );
    sat_pair_add #(.W(W)) u_sb (
      .hi  (opb[(2*p+1)*W +: W]),
      .lo  (opb[(2*p)*W +: W]),
      .sum (y[(PAIRS+p)*W +: W])
    );
  end
endmodule

// File: rtl/hsat_word_adder.sv
module hsat_word_adder #(
  parameter int ELEM_W = 16,
  parameter int LANE_W = 128
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    in_valid,
  output logic                    in_ready,
  input  logic [1:0]              mode,
  input  logic [2*LANE_W-1:0]     src_a,
  input  logic [2*LANE_W-1:0]     src_b,
  input  logic [2*LANE_W-1:0]     dst_old,
  output logic                    out_valid,
  input  logic                    out_ready,
  output logic [2*LANE_W-1:0]     result
);
  import hsat_pkg::*;

  localparam int VEC_W = 2 * LANE_W;

  hmode_e              mode_e;
  logic [LANE_W-1:0]   lo_first;
  logic [LANE_W-1:0]   lo_res;
  logic [LANE_W-1:0]   hi_res;
  logic [LANE_W-1:0]   hi_sel;
  logic [VEC_W-1:0]    result_q;
  logic                valid_q;
  logic                fire;

  assign mode_e   = hmode_e'(mode);
  assign lo_first = (mode_e == MODE_LEGACY) ? dst_old[LANE_W-1:0] : src_a[LANE_W-1:0];

  hadd_lane #(.W(ELEM_W), .LANE_W(LANE_W)) u_lane_lo (
    .opa (lo_first),
    .opb (src_b[LANE_W-1:0]),
    .y   (lo_res)
  );

  hadd_lane #(.W(ELEM_W), .LANE_W(LANE_W)) u_lane_hi (
    .opa (src_a[VEC_W-1:LANE_W]),
    .opb (src_b[VEC_W-1:LANE_W]),
    .y   (hi_res)
  );

  always_comb begin
    case (mode_e)
      MODE_LEGACY: hi_sel = dst_old[VEC_W-1:LANE_W];
      MODE_V256:   hi_sel = hi_res;
      default:     hi_sel = '0;
    endcase
  end

  assign in_ready = !valid_q || out_ready;
  assign fire     = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q  <= 1'b0;
      result_q <= '0;
    end else if (fire) begin
      valid_q  <= 1'b1;
      result_q <= {hi_sel, lo_res};
    end else if (out_ready) begin
      valid_q  <= 1'b0;
    end
  end

  assign out_valid = valid_q;
  assign result    = result_q;

  // R7: accepted transfer yields a valid result on the next cycle
  p_valid_after_fire_r7: assert property (@(posedge clk) disable iff (rst)
    fire |=> out_valid);

  // R9: a stalled result is held intact
  p_hold_on_stall_r9: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(result)));

  // R4: zeroing mode clears the upper lane
  p_zero_upper_r4: assert property (@(posedge clk) disable iff (rst)
    (fire && mode[0]) |=> (result[VEC_W-1:LANE_W] == '0));

  // R5: legacy mode carries the prior upper half
  p_legacy_keep_r5: assert property (@(posedge clk) disable iff (rst)
    (fire && mode == 2'b00) |=> (result[VEC_W-1:LANE_W] == $past(dst_old[VEC_W-1:LANE_W])));

  // R8: reset empties the output register
  p_reset_clear_r8: assert property (@(posedge clk)
    rst |=> (!out_valid && result == '0));
endmodule

// File: tb/sim_hsat_word_adder.sv
`timescale 1ns/1ps
module sim_hsat_word_adder;
  logic         clk = 1'b0;
  logic         rst;
  logic         in_valid;
  logic         in_ready;
  logic [1:0]   mode;
  logic [255:0] src_a, src_b, dst_old;
  logic         out_valid;
  logic         out_ready;
  logic [255:0] result;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  always #2.5 clk = ~clk;

  hsat_word_adder u0 (
    .clk, .rst, .in_valid, .in_ready, .mode, .src_a, .src_b, .dst_old,
    .out_valid, .out_ready, .result
  );

  function automatic logic [15:0] sat16(input logic [15:0] h, input logic [15:0] l);
    int s;
    s = $signed(h) + $signed(l);
    if (s > 32767) return 16'h7FFF;
    if (s < -32768) return 16'h8000;
    return s[15:0];
  endfunction

  function automatic logic [127:0] lane_ref(input logic [127:0] a, input logic [127:0] b);
    logic [127:0] r;
    for (int k = 0; k < 4; k++) begin
      r[k*16 +: 16]     = sat16(a[(2*k+1)*16 +: 16], a[(2*k)*16 +: 16]);
      r[(k+4)*16 +: 16] = sat16(b[(2*k+1)*16 +: 16], b[(2*k)*16 +: 16]);
    end
    return r;
  endfunction

  function automatic logic [255:0] model(input logic [1:0] m, input logic [255:0] a,
                                         input logic [255:0] b, input logic [255:0] d);
    if (m == 2'b00) return {d[255:128], lane_ref(d[127:0], b[127:0])};
    if (m == 2'b10) return {lane_ref(a[255:128], b[255:128]), lane_ref(a[127:0], b[127:0])};
    return {128'h0, lane_ref(a[127:0], b[127:0])};
  endfunction

  function automatic logic [255:0] rnd256();
    logic [255:0] v;
    for (int i = 0; i < 8; i++) v[i*32 +: 32] = $urandom;
    return v;
  endfunction

  task automatic check(input string req, input logic [255:0] got, input logic [255:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic send(input logic [1:0] m, input logic [255:0] a,
                      input logic [255:0] b, input logic [255:0] d);
    @(negedge clk);
    mode = m; src_a = a; src_b = b; dst_old = d; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic t_reset();
    rst = 1'b1; in_valid = 1'b0; out_ready = 1'b1; mode = 2'b10;
    src_a = '0; src_b = '0; dst_old = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check("R8 out_valid", {255'h0, out_valid}, 256'h0);
    check("R8 result", result, 256'h0);
    check("R10 in_ready idle", {255'h0, in_ready}, 256'h1);
  endtask

  task automatic t_saturate();
    logic [127:0] a;
    logic [255:0] exp;
    a = {16'h0001, 16'hFFFF, 16'h8000, 16'h8000, 16'hFFFF, 16'h8000, 16'h0001, 16'h7FFF};
    send(2'b01, {128'h0, a}, 256'h0, 256'h0);
    exp = {128'h0, 64'h0, 16'h0000, 16'h8000, 16'h8000, 16'h7FFF};
    check("R6 clamp cases", result, exp);
  endtask

  task automatic t_placement();
    logic [127:0] a, b;
    a = {16'd8, 16'd7, 16'd6, 16'd5, 16'd4, 16'd3, 16'd2, 16'd1};
    b = {16'd80, 16'd70, 16'd60, 16'd50, 16'd40, 16'd30, 16'd20, 16'd10};
    send(2'b01, {128'h0, a}, {128'h0, b}, 256'h0);
    check("R2 R1 word order", result,
          {128'h0, 16'd150, 16'd110, 16'd70, 16'd30, 16'd15, 16'd11, 16'd7, 16'd3});
  endtask

  task automatic t_latency();
    logic [255:0] a, b;
    a = rnd256(); b = rnd256();
    @(negedge clk);
    mode = 2'b10; src_a = a; src_b = b; in_valid = 1'b1;
    check("R7 not valid before edge", {255'h0, out_valid}, 256'h0);
    @(negedge clk);
    in_valid = 1'b0;
    check("R7 valid after edge", {255'h0, out_valid}, 256'h1);
    check("R7 result after edge", result, model(2'b10, a, b, 256'h0));
    @(negedge clk);
    check("R10 valid drops when drained", {255'h0, out_valid}, 256'h0);
  endtask

  task automatic t_mode256();
    logic [255:0] a, b, r1;
    a = rnd256(); b = rnd256();
    send(2'b10, a, b, rnd256());
    check("R3 256-bit lanes", result, model(2'b10, a, b, 256'h0));
    r1 = result;
    a[127:0] = ~a[127:0]; b[127:0] = ~b[127:0];
    send(2'b10, a, b, 256'h0);
    check("R3 upper lane ignores lower halves", {128'h0, result[255:128]}, {128'h0, r1[255:128]});
  endtask

  task automatic t_mode128();
    logic [255:0] a, b;
    for (int m = 1; m < 4; m += 2) begin
      a = rnd256(); b = rnd256();
      send(m[1:0], a, b, rnd256());
      check("R4 zero upper", result, model(m[1:0], a, b, 256'h0));
    end
  endtask

  task automatic t_legacy();
    logic [255:0] b, d;
    b = rnd256(); d = rnd256();
    send(2'b00, rnd256(), b, d);
    check("R5 legacy first", result, model(2'b00, 256'h0, b, d));
    send(2'b00, ~rnd256(), b, d);
    check("R5 src_a no effect", result, model(2'b00, 256'h0, b, d));
  endtask

  task automatic t_backpressure();
    logic [255:0] a1, a2, b;
    a1 = rnd256(); a2 = rnd256(); b = rnd256();
    @(negedge clk);
    out_ready = 1'b0;
    mode = 2'b10; src_a = a1; src_b = b; in_valid = 1'b1;
    @(negedge clk);
    src_a = a2;
    check("R9 in_ready low on stall", {255'h0, in_ready}, 256'h0);
    repeat (3) @(negedge clk);
    check("R9 result held", result, model(2'b10, a1, b, 256'h0));
    check("R9 valid held", {255'h0, out_valid}, 256'h1);
    out_ready = 1'b1;
    #0.5;
    check("R10 ready with out_ready", {255'h0, in_ready}, 256'h1);
    @(negedge clk);
    in_valid = 1'b0;
    check("R10 next accepted", result, model(2'b10, a2, b, 256'h0));
    @(negedge clk);
  endtask

  task automatic t_random();
    logic [255:0] a, b, d;
    logic [1:0] m;
    for (int i = 0; i < 40; i++) begin
      a = rnd256(); b = rnd256(); d = rnd256(); m = i[1:0];
      send(m, a, b, d);
      check("R1 random vector", result, model(m, a, b, d));
    end
  endtask

  task automatic report();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  endtask

  initial begin
    t_reset();
    t_saturate();
    t_placement();
    t_latency();
    t_mode256();
    t_mode128();
    t_legacy();
    t_backpressure();
    t_random();
    report();
  end

  initial begin
    #100000;
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    report();
  end
endmodule